// File: doc/BRIEF.md
# Invertible Lane Diffusion Network

This block spreads the effect of every bit of a stored word across the other bits of its own lane. On the write side it takes plain data and a keystream word, XORs them, and then runs each lane through a fixed substitution/permutation network. On the read side it runs the stored word through the exact inverse network and only then removes the keystream by XOR. A bit flipped by tampering in a stored lane therefore comes back as damage to several bits of that lane instead of a single predictable bit.

Lanes are processed in isolation, so a write that updates only some byte lanes of a word leaves the other stored lanes valid. The lane width and the number of rounds are parameters. With zero rounds the network reduces to wires and only the keystream XOR remains. The block is purely combinational and has no clock.

Top module: `lane_scramble_path`

## Requirements
- R1: `wr_word_o` equals, for each lane, F(lane of `wr_data_i` XOR `wr_keystream_i`). F applies ROUNDS rounds. In each round every 4-bit nibble n is replaced by S[n], with S = C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (hex, for n = 0..15), and then bit i of the lane moves to bit position (3*i) mod LANE_W.
- R2: `rd_data_o` equals, for each lane, G(lane of `rd_word_i`) XOR that lane of `rd_keystream_i`. G is the inverse of F: it undoes the permutation, applies the inverse S-box, and runs the rounds in reverse order.
- R3: Feeding the write output back with the same keystream returns the original data for all 256 lane values at every round count from 0 to 3.
- R4: With ROUNDS = 0, `wr_word_o` = `wr_data_i` XOR `wr_keystream_i` and `rd_data_o` = `rd_word_i` XOR `rd_keystream_i`.
- R5: Changing the inputs of one lane leaves the outputs of every other lane unchanged.
- R6: With ROUNDS = 2, flipping any single bit of a stored lane changes the recovered lane. Averaged over all 256 lane values and all 8 bit positions, more than 2 recovered bits change.
- R7: The keystream is applied outside the network. A write of (data, ks) stores the same word as a write of (data XOR ks, 0). On a read, flipping one keystream bit flips only the same bit of `rd_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data_i | input | DATA_W | Plain data to be stored |
| wr_keystream_i | input | DATA_W | Keystream word for the write |
| wr_word_o | output | DATA_W | Diffused word sent to storage |
| rd_word_i | input | DATA_W | Word read back from storage |
| rd_keystream_i | input | DATA_W | Keystream word for the read |
| rd_data_o | output | DATA_W | Recovered plain data |

## Verification
Immediate assertions inside the top re-run the opposite network on each path at every input change. They confirm that the write output inverts back to the keyed input and that the read output maps forward onto the stored word (R3). They also confirm the pass-through form when zero rounds are selected (R4). Only the bench scenarios can show that the network matches the stated S-box and bit positions (R1, R2). The same is true of lane isolation (R5), the measured avalanche (R6) and the placement of the keystream XOR (R7). The bench compares all four round counts against its own arithmetic model across every lane value.

// File: rtl/lane_mix_pkg.sv
package lane_mix_pkg;

    typedef logic [3:0] nib_t;

    // Substitution table, entry n held in bits [4n+3:4n]
    localparam logic [63:0] SBOX_TABLE = 64'h2174_8FE3_DA09_B65C;

    // Multiplier for the bit spread; coprime with any lane width that passes the checks
    localparam int unsigned SPREAD_MUL = 3;

    function automatic nib_t sbox_fwd(nib_t x);
        return SBOX_TABLE[{x, 2'b00} +: 4];
    endfunction

    function automatic nib_t sbox_inv(nib_t y);
        nib_t res;
        res = '0;
        for (int k = 0; k < 16; k++) begin
            if (sbox_fwd(nib_t'(k)) == y) res = nib_t'(k);
        end
        return res;
    endfunction

    function automatic int unsigned spread_pos(int unsigned i, int unsigned w);
        return (SPREAD_MUL * i) % w;
    endfunction

endpackage

// File: rtl/lane_mix_fwd.sv
module lane_mix_fwd
    import lane_mix_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned ROUNDS = 2
) (
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);
    localparam int unsigned NIBS = LANE_W / 4;

    logic [LANE_W-1:0] stage [ROUNDS+1];

    assign stage[0] = din;

    for (genvar r = 0; r < ROUNDS; r++) begin : g_round
        logic [LANE_W-1:0] subst;
        logic [LANE_W-1:0] moved;

        always_comb begin
            for (int n = 0; n < NIBS; n++) begin
                subst[4*n +: 4] = sbox_fwd(stage[r][4*n +: 4]);
            end
        end

        always_comb begin
            moved = '0;
            for (int i = 0; i < LANE_W; i++) begin
                moved[spread_pos(i, LANE_W)] = subst[i];
            end
        end

        assign stage[r+1] = moved;
    end

    assign dout = stage[ROUNDS];

endmodule

// File: rtl/lane_mix_inv.sv
module lane_mix_inv
    import lane_mix_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned ROUNDS = 2
) (
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);
    localparam int unsigned NIBS = LANE_W / 4;

    logic [LANE_W-1:0] stage [ROUNDS+1];

    assign stage[0] = din;

    // Round r here undoes forward round ROUNDS-1-r
    for (genvar r = 0; r < ROUNDS; r++) begin : g_round
        logic [LANE_W-1:0] gathered;
        logic [LANE_W-1:0] unsub;

        always_comb begin
            for (int i = 0; i < LANE_W; i++) begin
                gathered[i] = stage[r][spread_pos(i, LANE_W)];
            end
        end

        always_comb begin
            for (int n = 0; n < NIBS; n++) begin
                unsub[4*n +: 4] = sbox_inv(gathered[4*n +: 4]);
            end
        end

        assign stage[r+1] = unsub;
    end

    assign dout = stage[ROUNDS];

endmodule

// File: rtl/lane_scramble_path.sv
module lane_scramble_path
    import lane_mix_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned ROUNDS = 2
) (
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] wr_keystream_i,
    output logic [DATA_W-1:0] wr_word_o,
    input  logic [DATA_W-1:0] rd_word_i,
    input  logic [DATA_W-1:0] rd_keystream_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int unsigned NUM_LANES = DATA_W / LANE_W;

    if ((DATA_W % LANE_W) != 0) begin : g_bad_data_w
        $error("DATA_W must be a multiple of LANE_W");
    end
    if ((LANE_W % 4) != 0 || (LANE_W % SPREAD_MUL) == 0) begin : g_bad_lane_w
        $error("LANE_W must be a multiple of 4 and coprime with the spread multiplier");
    end

    logic [DATA_W-1:0] wr_keyed;
    logic [DATA_W-1:0] rd_unmixed;

    // Write: keystream first, then diffusion
    assign wr_keyed = wr_data_i ^ wr_keystream_i;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        lane_mix_fwd #(.LANE_W(LANE_W), .ROUNDS(ROUNDS)) u_fwd (
            .din  (wr_keyed[l*LANE_W +: LANE_W]),
            .dout (wr_word_o[l*LANE_W +: LANE_W])
        );
        lane_mix_inv #(.LANE_W(LANE_W), .ROUNDS(ROUNDS)) u_inv (
            .din  (rd_word_i[l*LANE_W +: LANE_W]),
            .dout (rd_unmixed[l*LANE_W +: LANE_W])
        );
    end

    // Read: inverse diffusion first, keystream last
    assign rd_data_o = rd_unmixed ^ rd_keystream_i;

    // ------------------------------------------------------------
    // Cross-checks: each path is run through the opposite network
    // ------------------------------------------------------------
    logic [DATA_W-1:0] chk_wr_back;
    logic [DATA_W-1:0] chk_rd_fwd;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
        lane_mix_inv #(.LANE_W(LANE_W), .ROUNDS(ROUNDS)) u_chk_inv (
            .din  (wr_word_o[l*LANE_W +: LANE_W]),
            .dout (chk_wr_back[l*LANE_W +: LANE_W])
        );
        lane_mix_fwd #(.LANE_W(LANE_W), .ROUNDS(ROUNDS)) u_chk_fwd (
            .din  (rd_data_o[l*LANE_W +: LANE_W] ^ rd_keystream_i[l*LANE_W +: LANE_W]),
            .dout (chk_rd_fwd[l*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        p_wr_roundtrip_r3: assert ((chk_wr_back ^ wr_keystream_i) == wr_data_i)
            else $error("write word does not invert back to write data");
        p_rd_roundtrip_r3: assert (chk_rd_fwd == rd_word_i)
            else $error("read data does not map forward onto stored word");
    end

    if (ROUNDS == 0) begin : g_zero_chk
        always_comb begin
            p_wr_passthru_r4: assert (wr_word_o == (wr_data_i ^ wr_keystream_i))
                else $error("zero-round write is not a plain XOR");
            p_rd_passthru_r4: assert (rd_data_o == (rd_word_i ^ rd_keystream_i))
                else $error("zero-round read is not a plain XOR");
        end
    end

endmodule

// File: tb/lane_scramble_path_test.sv
module lane_scramble_path_test;

    localparam int DW = 16;
    localparam int NR = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [DW-1:0] wr_data, wr_ks, rd_ks;
    logic [DW-1:0] rdw [NR];
    logic [DW-1:0] wrw [NR];
    logic [DW-1:0] rdd [NR];

    for (genvar g = 0; g < NR; g++) begin : g_dut
        lane_scramble_path #(.DATA_W(DW), .LANE_W(8), .ROUNDS(g)) uut (
            .wr_data_i      (wr_data),
            .wr_keystream_i (wr_ks),
            .wr_word_o      (wrw[g]),
            .rd_word_i      (rdw[g]),
            .rd_keystream_i (rd_ks),
            .rd_data_o      (rdd[g])
        );
    end

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    logic [3:0] sb  [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                             4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};
    logic [3:0] sbi [16];

    function automatic logic [7:0] ref_fwd(logic [7:0] v, int rounds);
        logic [7:0] t, m;
        m = v;
        for (int r = 0; r < rounds; r++) begin
            t = {sb[m[7:4]], sb[m[3:0]]};
            for (int i = 0; i < 8; i++) m[(3*i) % 8] = t[i];
        end
        return m;
    endfunction

    function automatic logic [7:0] ref_inv(logic [7:0] v, int rounds);
        logic [7:0] t, m;
        m = v;
        for (int r = 0; r < rounds; r++) begin
            for (int i = 0; i < 8; i++) t[i] = m[(3*i) % 8];
            m = {sbi[t[7:4]], sbi[t[3:0]]};
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] ref_wr(logic [DW-1:0] d, logic [DW-1:0] k, int rounds);
        logic [DW-1:0] x;
        x = d ^ k;
        return {ref_fwd(x[15:8], rounds), ref_fwd(x[7:0], rounds)};
    endfunction

    function automatic logic [DW-1:0] ref_rd(logic [DW-1:0] w, logic [DW-1:0] k, int rounds);
        return {ref_inv(w[15:8], rounds), ref_inv(w[7:0], rounds)} ^ k;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                if (sb[x] == 4'(y)) sbi[y] = 4'(x);

        // Quiescent state: all-zero inputs (R1, R2)
        wr_data = '0; wr_ks = '0; rd_ks = '0;
        for (int g = 0; g < NR; g++) rdw[g] = '0;
        settle();
        for (int g = 0; g < NR; g++) begin
            check("R1 zero input write", wrw[g], ref_wr('0, '0, g));
            check("R2 zero input read",  rdd[g], ref_rd('0, '0, g));
        end

        // Exhaustive lane sweep
        for (int v = 0; v < 256; v++) begin
            @(posedge clk);
            wr_data = {8'(v) ^ 8'hA5, 8'(v)};
            wr_ks   = {8'(v * 13 + 1), 8'(v * 7 + 3)};
            rd_ks   = wr_ks;
            for (int g = 0; g < NR; g++) rdw[g] = ref_wr(wr_data, wr_ks, g);
            settle();
            for (int g = 0; g < NR; g++) begin
                if (g == 0) check("R4 zero rounds write", wrw[g], wr_data ^ wr_ks);
                else        check("R1 write word", wrw[g], ref_wr(wr_data, wr_ks, g));
                check("R3 round trip", rdd[g], wr_data);
            end

            @(posedge clk);
            rd_ks = {8'(v * 5 + 11), 8'(v * 3 + 29)};
            for (int g = 0; g < NR; g++) rdw[g] = {8'(v), ~8'(v)};
            settle();
            for (int g = 0; g < NR; g++) begin
                if (g == 0) check("R4 zero rounds read", rdd[g], rdw[g] ^ rd_ks);
                else        check("R2 read data", rdd[g], ref_rd(rdw[g], rd_ks, g));
            end
        end

        // Keystream placement (R7)
        for (int v = 0; v < 16; v++) begin
            logic [DW-1:0] d, k, w_keyed, r_base;
            d = 16'(v * 4099 + 77);
            k = 16'(v * 2311 + 5);
            @(posedge clk);
            wr_data = d; wr_ks = k;
            settle();
            w_keyed = wrw[2];
            @(posedge clk);
            wr_data = d ^ k; wr_ks = '0;
            settle();
            check("R7 write keystream applied first", wrw[2], w_keyed);

            @(posedge clk);
            rd_ks = '0; rdw[2] = d;
            settle();
            r_base = rdd[2];
            @(posedge clk);
            rd_ks = 16'(1) << (v % 16);
            settle();
            check("R7 read keystream applied last", rdd[2], r_base ^ (16'(1) << (v % 16)));
        end

        // Lane isolation (R5)
        for (int v = 0; v < 16; v++) begin
            logic [DW-1:0] w0, r0;
            @(posedge clk);
            wr_data = {8'h00, 8'h5A}; wr_ks = {8'h00, 8'h33};
            rd_ks = {8'h00, 8'h0F}; rdw[2] = {8'h00, 8'hC3};
            settle();
            w0 = wrw[2]; r0 = rdd[2];
            @(posedge clk);
            wr_data[15:8] = 8'(v * 17 + 1); wr_ks[15:8] = 8'(v * 9 + 2);
            rd_ks[15:8] = 8'(v * 31 + 4); rdw[2][15:8] = 8'(v * 11 + 8);
            settle();
            check("R5 lower write lane isolated", {8'h00, wrw[2][7:0]}, {8'h00, w0[7:0]});
            check("R5 lower read lane isolated",  {8'h00, rdd[2][7:0]}, {8'h00, r0[7:0]});
        end

        // Avalanche on the read path at two rounds (R6)
        begin
            int total;
            total = 0;
            rd_ks = '0;
            for (int v = 0; v < 256; v++) begin
                logic [7:0] base;
                @(posedge clk);
                rdw[2] = {8'h00, 8'(v)};
                settle();
                base = rdd[2][7:0];
                for (int b = 0; b < 8; b++) begin
                    logic [7:0] diff;
                    @(posedge clk);
                    rdw[2] = {8'h00, 8'(v) ^ (8'(1) << b)};
                    settle();
                    diff = rdd[2][7:0] ^ base;
                    tests++;
                    if (diff == 8'h00) begin
                        fails++;
                        $display("FAIL R6 single flip unchanged: actual %h expected nonzero", diff);
                    end
                    total += $countones(diff);
                end
            end
            tests++;
            if (total <= 2 * 256 * 8) begin
                fails++;
                $display("FAIL R6 average spread: actual %0d expected > %0d", total, 2 * 256 * 8);
            end
        end

        done = 1;
        finish_run();
    end

endmodule